// File: doc/BRIEF.md
# In-Order Retirement Reorder Buffer

This block keeps instruction completion in program order while execution runs out of order. Each instruction takes a slot at the tail when it is issued and receives that slot's index as its tag. Execution units report by tag when an instruction starts executing and when it finishes. A finish report can carry an exception flag. Slots leave from the head, oldest first, at up to two per cycle.

A store counts as finished once its operands are available, but it is handed to the data cache only when it retires from the head slot. An exception is not raised when it is reported. It is raised when the faulting instruction is the oldest one in the buffer. The buffer then drops that instruction and every younger one, so no later result reaches architectural state and interrupts stay precise.

The allocate port is a valid/ready stream. An allocation happens in a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` does not depend on `alloc_valid`. The retire side is also valid/ready: both lanes hand over in a cycle where `ret_ready` is high, and their valids do not depend on `ret_ready`. While `ret_ready` is low, the head is held. The start, finish, flush, store-release and exception pins are plain strobes with no back-pressure. `DEPTH` must be a power of two.

Top module: `inorder_rob`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1 and `alloc_tag` is 0. `ret0_valid`, `ret1_valid`, `st_rel_valid` and `exc_valid` are all 0.
- R2: Each accepted allocation takes the tag shown on `alloc_tag`. Successive allocations get consecutive tags, counting modulo DEPTH (8).
- R3: `alloc_ready` is 0 while DEPTH entries are held at the start of the cycle, even if entries retire in that cycle. It is also 0 while `flush` or `exc_valid` is high. A refused request changes no state.
- R4: `ret0_valid` is 1 only when the oldest entry has finished without an exception. `ret0_tag` is then that entry's tag. Younger entries that finished early do not retire ahead of it.
- R5: `ret1_valid` (tag = `ret0_tag`+1 mod DEPTH) requires all three of the following:
  - `ret0_valid` is 1.
  - The second-oldest entry has finished without an exception.
  - The second-oldest entry is not a store.
- R6: While `ret_ready` is 0, no entry leaves. `ret0_valid` and `ret0_tag` hold until the handshake.
- R7: `st_rel_valid` pulses, with `st_rel_tag` equal to `ret0_tag`, only in a cycle where a store retires on lane 0 with `ret_ready` high. A store that finishes below the head produces no pulse.
- R8: When the oldest entry has finished with an exception, the following hold for that cycle:
  - `exc_valid` is 1 and `exc_tag` is that entry's tag.
  - Nothing retires.
  - In the next cycle the buffer is empty and `alloc_tag` equals the faulting tag.
- R9: A cycle with `flush` high retires nothing and raises no exception. It leaves the buffer empty, and the next allocation takes the tag that was oldest.
- R10: A finish report for a free slot, or for a slot that has already finished, is ignored. Its exception flag is dropped too.
- R11: A finish report is accepted from both the issued state and the in-execution state. `start_valid` moves an issued slot to in-execution without changing retirement order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all entries this cycle |
| alloc_valid | input | 1 | Allocation request |
| alloc_is_store | input | 1 | The allocated instruction is a store |
| alloc_ready | output | 1 | Allocation can be accepted |
| alloc_tag | output | 3 | Tag the next allocation receives |
| start_valid | input | 1 | Execution started for `start_tag` |
| start_tag | input | 3 | Tag entering execution |
| fin_valid | input | 1 | Finish report |
| fin_tag | input | 3 | Tag that finished |
| fin_exc | input | 1 | Finished instruction faulted |
| ret_ready | input | 1 | Retirement consumer can accept |
| ret0_valid | output | 1 | Oldest entry retiring |
| ret0_tag | output | 3 | Tag on lane 0 |
| ret1_valid | output | 1 | Second entry retiring |
| ret1_tag | output | 3 | Tag on lane 1 |
| st_rel_valid | output | 1 | Release the retiring store to the cache |
| st_rel_tag | output | 3 | Tag of the released store |
| exc_valid | output | 1 | Precise exception raised |
| exc_tag | output | 3 | Tag of the faulting instruction |

## Verification
The assertions place no legality rule on the tag inputs: a finish or start report may name any slot, in any state. The properties about emptiness after an exception or a flush rely only on the flush taking priority. The stimulus sends finish and start reports to random tags, including free and already-finished slots, and sends repeated reports with random exception flags. It also toggles `ret_ready` freely and injects flushes at random. A reference queue in program order then predicts every output in every cycle.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_ISSUED = 2'd1,
    SLOT_EXEC   = 2'd2,
    SLOT_DONE   = 2'd3
  } slot_state_e;
endpackage

// File: rtl/rob_slots.sv
`timescale 1ns/1ps
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic [DEPTH-1:0]      release_i,
  input  logic                  alloc_we_i,
  input  logic [TW-1:0]         alloc_idx_i,
  input  logic                  alloc_store_i,
  input  logic                  start_we_i,
  input  logic [TW-1:0]         start_idx_i,
  input  logic                  fin_we_i,
  input  logic [TW-1:0]         fin_idx_i,
  input  logic                  fin_exc_i,
  output logic [DEPTH-1:0][1:0] state_o,
  output logic [DEPTH-1:0]      store_o,
  output logic [DEPTH-1:0]      exc_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    slot_state_e st_q;
    logic        sto_q;
    logic        exc_q;
    logic        hit_alloc, hit_start, hit_fin, busy;

    assign hit_alloc = alloc_we_i && (alloc_idx_i == TW'(i));
    assign hit_start = start_we_i && (start_idx_i == TW'(i));
    assign hit_fin   = fin_we_i && (fin_idx_i == TW'(i));
    assign busy      = (st_q == SLOT_ISSUED) || (st_q == SLOT_EXEC);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= SLOT_FREE;
        sto_q <= 1'b0;
        exc_q <= 1'b0;
      end else if (clear_i || release_i[i]) begin
        st_q <= SLOT_FREE;
      end else if (hit_alloc) begin
        st_q  <= SLOT_ISSUED;
        sto_q <= alloc_store_i;
        exc_q <= 1'b0;
      end else if (hit_fin && busy) begin
        st_q  <= SLOT_DONE;
        exc_q <= fin_exc_i;
      end else if (hit_start && (st_q == SLOT_ISSUED)) begin
        st_q <= SLOT_EXEC;
      end
    end

    assign state_o[i] = st_q;
    assign store_o[i] = sto_q;
    assign exc_o[i]   = exc_q;
  end
endmodule

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [1:0]    pop_i,
  output logic [TW-1:0] head_o,
  output logic [TW-1:0] tail_o,
  output logic [CW-1:0] count_o
);
  logic [TW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      tail_q  <= head_q;
      count_q <= '0;
    end else begin
      head_q  <= head_q + TW'(pop_i);
      tail_q  <= tail_q + TW'(push_i);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;
endmodule

// File: rtl/rob_retire.sv
`timescale 1ns/1ps
module rob_retire
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = TW + 1
) (
  input  logic [TW-1:0]         head_i,
  input  logic [CW-1:0]         count_i,
  input  logic [DEPTH-1:0][1:0] state_i,
  input  logic [DEPTH-1:0]      store_i,
  input  logic [DEPTH-1:0]      exc_i,
  input  logic                  ret_ready_i,
  input  logic                  flush_i,
  output logic                  ret0_valid_o,
  output logic [TW-1:0]         ret0_tag_o,
  output logic                  ret1_valid_o,
  output logic [TW-1:0]         ret1_tag_o,
  output logic                  st_rel_o,
  output logic                  exc_valid_o,
  output logic [1:0]            pop_o,
  output logic [DEPTH-1:0]      release_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] idx0, idx1;
  logic          done0, done1, fire0, fire1;

  assign idx0  = head_i;
  assign idx1  = head_i + ONE;
  assign done0 = (count_i != '0) && (state_i[idx0] == SLOT_DONE);
  assign done1 = (count_i > CW'(1)) && (state_i[idx1] == SLOT_DONE);

  assign exc_valid_o  = !flush_i && done0 && exc_i[idx0];
  assign ret0_valid_o = !flush_i && done0 && !exc_i[idx0];
  assign ret1_valid_o = ret0_valid_o && done1 && !exc_i[idx1] && !store_i[idx1];
  assign ret0_tag_o   = idx0;
  assign ret1_tag_o   = idx1;

  assign fire0    = ret0_valid_o && ret_ready_i;
  assign fire1    = ret1_valid_o && ret_ready_i;
  assign st_rel_o = fire0 && store_i[idx0];
  assign pop_o    = {1'b0, fire0} + {1'b0, fire1};

  always_comb begin
    release_o = '0;
    if (fire0) release_o[idx0] = 1'b1;
    if (fire1) release_o[idx1] = 1'b1;
  end
endmodule

// File: rtl/inorder_rob.sv
`timescale 1ns/1ps
module inorder_rob #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc_valid,
  input  logic          alloc_is_store,
  output logic          alloc_ready,
  output logic [TW-1:0] alloc_tag,
  input  logic          start_valid,
  input  logic [TW-1:0] start_tag,
  input  logic          fin_valid,
  input  logic [TW-1:0] fin_tag,
  input  logic          fin_exc,
  input  logic          ret_ready,
  output logic          ret0_valid,
  output logic [TW-1:0] ret0_tag,
  output logic          ret1_valid,
  output logic [TW-1:0] ret1_tag,
  output logic          st_rel_valid,
  output logic [TW-1:0] st_rel_tag,
  output logic          exc_valid,
  output logic [TW-1:0] exc_tag
);
  logic [TW-1:0]         head_q, tail_q;
  logic [CW-1:0]         count_q;
  logic [DEPTH-1:0][1:0] slot_state;
  logic [DEPTH-1:0]      slot_store, slot_exc, release_mask;
  logic [1:0]            pop_n;
  logic                  push, clear_all;

  assign clear_all   = flush || exc_valid;
  assign alloc_ready = (count_q != CW'(DEPTH)) && !clear_all;
  assign push        = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_q;
  assign exc_tag     = head_q;
  assign st_rel_tag  = ret0_tag;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_all),
    .push_i  (push),
    .pop_i   (pop_n),
    .head_o  (head_q),
    .tail_o  (tail_q),
    .count_o (count_q)
  );

  rob_slots #(.DEPTH(DEPTH)) u_slots (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear_all),
    .release_i     (release_mask),
    .alloc_we_i    (push),
    .alloc_idx_i   (tail_q),
    .alloc_store_i (alloc_is_store),
    .start_we_i    (start_valid),
    .start_idx_i   (start_tag),
    .fin_we_i      (fin_valid),
    .fin_idx_i     (fin_tag),
    .fin_exc_i     (fin_exc),
    .state_o       (slot_state),
    .store_o       (slot_store),
    .exc_o         (slot_exc)
  );

  rob_retire #(.DEPTH(DEPTH)) u_retire (
    .head_i       (head_q),
    .count_i      (count_q),
    .state_i      (slot_state),
    .store_i      (slot_store),
    .exc_i        (slot_exc),
    .ret_ready_i  (ret_ready),
    .flush_i      (flush),
    .ret0_valid_o (ret0_valid),
    .ret0_tag_o   (ret0_tag),
    .ret1_valid_o (ret1_valid),
    .ret1_tag_o   (ret1_tag),
    .st_rel_o     (st_rel_valid),
    .exc_valid_o  (exc_valid),
    .pop_o        (pop_n),
    .release_o    (release_mask)
  );
endmodule

// File: rtl/inorder_rob_chk.sv
`timescale 1ns/1ps
module inorder_rob_chk #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = TW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          alloc_ready,
  input logic          ret_ready,
  input logic          ret0_valid,
  input logic [TW-1:0] ret0_tag,
  input logic          ret1_valid,
  input logic          st_rel_valid,
  input logic [TW-1:0] st_rel_tag,
  input logic          exc_valid,
  input logic [CW-1:0] count
);
  // R3
  full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !alloc_ready);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5
  lane1_needs_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret1_valid |-> ret0_valid);

  // R6
  stall_holds_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret0_valid && !ret_ready && !flush) |=> (flush || (ret0_valid && ret0_tag == $past(ret0_tag))));

  // R7
  store_at_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rel_valid |-> (ret0_valid && ret_ready && st_rel_tag == ret0_tag));

  // R8
  exc_blocks_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!ret0_valid && !st_rel_valid));

  // R8
  exc_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (count == '0));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

bind inorder_rob inorder_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .alloc_ready  (alloc_ready),
  .ret_ready    (ret_ready),
  .ret0_valid   (ret0_valid),
  .ret0_tag     (ret0_tag),
  .ret1_valid   (ret1_valid),
  .st_rel_valid (st_rel_valid),
  .st_rel_tag   (st_rel_tag),
  .exc_valid    (exc_valid),
  .count        (count_q)
);

// File: tb/inorder_rob_test.sv
`timescale 1ns/1ps
module inorder_rob_test;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, flush, alloc_valid, alloc_is_store, alloc_ready;
  logic [2:0] alloc_tag, start_tag, fin_tag, ret0_tag, ret1_tag, st_rel_tag, exc_tag;
  logic       start_valid, fin_valid, fin_exc, ret_ready;
  logic       ret0_valid, ret1_valid, st_rel_valid, exc_valid;

  inorder_rob #(.DEPTH(DEPTH)) uut (.*);

  int checks = 0;
  int errors = 0;

  // reference model: program-order queue of live tags
  int q[$];
  bit m_store[DEPTH], m_fin[DEPTH], m_exc[DEPTH];
  int m_head = 0, m_tail = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit live(int t);
    foreach (q[k]) if (q[k] == t) return 1'b1;
    return 1'b0;
  endfunction

  // monitor: compares outputs with the model, then applies this cycle's inputs
  task automatic step();
    bit e_exc, e_r0, e_r1, e_ar, e_sr;
    e_exc = !flush && q.size() > 0 && m_fin[q[0]] && m_exc[q[0]];
    e_r0  = !flush && q.size() > 0 && m_fin[q[0]] && !m_exc[q[0]];
    e_r1  = e_r0 && q.size() > 1 && m_fin[q[1]] && !m_exc[q[1]] && !m_store[q[1]];
    e_ar  = q.size() < DEPTH && !flush && !e_exc;
    e_sr  = e_r0 && ret_ready && m_store[q[0]];
    chk("R8", "exc_valid", exc_valid, e_exc);
    if (e_exc) chk("R8", "exc_tag", exc_tag, q[0]);
    chk("R4", "ret0_valid", ret0_valid, e_r0);
    if (e_r0) chk("R4", "ret0_tag", ret0_tag, q[0]);
    chk("R5", "ret1_valid", ret1_valid, e_r1);
    if (e_r1) chk("R5", "ret1_tag", ret1_tag, q[1]);
    chk("R3", "alloc_ready", alloc_ready, e_ar);
    chk("R2", "alloc_tag", alloc_tag, m_tail);
    chk("R7", "st_rel_valid", st_rel_valid, e_sr);
    if (e_sr) chk("R7", "st_rel_tag", st_rel_tag, q[0]);
    if (flush) begin
      q.delete();
      m_tail = m_head;
    end else if (e_exc) begin
      m_tail = q[0];
      m_head = q[0];
      q.delete();
    end else begin
      // R10: only live, unfinished entries accept a finish
      if (fin_valid && live(fin_tag) && !m_fin[fin_tag]) begin
        m_fin[fin_tag] = 1'b1;
        m_exc[fin_tag] = fin_exc;
      end
      if (e_r0 && ret_ready) begin
        void'(q.pop_front());
        if (e_r1) void'(q.pop_front());
        m_head = q.size() > 0 ? q[0] : m_tail;
      end
      if (alloc_valid && e_ar) begin
        q.push_back(m_tail);
        m_store[m_tail] = alloc_is_store;
        m_fin[m_tail] = 1'b0;
        m_exc[m_tail] = 1'b0;
        m_tail = (m_tail + 1) % DEPTH;
        if (q.size() == 1) m_head = q[0];
      end
    end
  endtask

  always @(negedge clk) begin
    #4;
    if (rst_n) step();
  end

  task automatic drv(bit av = 0, bit ast = 0, bit fv = 0, int ft = 0, bit fe = 0,
                     bit sv = 0, int stg = 0, bit fl = 0);
    alloc_valid = av; alloc_is_store = ast;
    fin_valid = fv; fin_tag = 3'(ft); fin_exc = fe;
    start_valid = sv; start_tag = 3'(stg); flush = fl;
    @(negedge clk);
    alloc_valid = 0; alloc_is_store = 0; fin_valid = 0; fin_exc = 0;
    start_valid = 0; flush = 0;
    #1;
  endtask

  task automatic alloc(bit st); drv(.av(1), .ast(st)); endtask
  task automatic fin(int t, bit e); drv(.fv(1), .ft(t), .fe(e)); endtask
  task automatic idle(); drv(); endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; flush = 0; alloc_valid = 0; alloc_is_store = 0;
    start_valid = 0; start_tag = 0; fin_valid = 0; fin_tag = 0; fin_exc = 0; ret_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "alloc_ready", alloc_ready, 1);
    chk("R1", "alloc_tag", alloc_tag, 0);
    chk("R1", "ret0_valid", ret0_valid, 0);
    chk("R1", "ret1_valid", ret1_valid, 0);
    chk("R1", "exc_valid", exc_valid, 0);
    chk("R1", "st_rel_valid", st_rel_valid, 0);

    // R4 out-of-order finish, in-order retire; R11 start then finish
    alloc(0); alloc(0); alloc(0);
    drv(.sv(1), .stg(1));
    fin(2, 0); fin(1, 0);
    chk("R4", "ret0_valid head unfinished", ret0_valid, 0);
    fin(0, 0);
    chk("R4", "ret0_tag", ret0_tag, 0);
    chk("R5", "ret1_valid pair", ret1_valid, 1);
    chk("R11", "ret1_tag after start", ret1_tag, 1);
    idle();
    chk("R5", "ret0_tag third", ret0_tag, 2);
    chk("R5", "ret1_valid none", ret1_valid, 0);
    idle();

    // R6 back-pressure
    ret_ready = 0;
    alloc(0); fin(3, 0);
    chk("R6", "ret0_valid held", ret0_valid, 1);
    idle(); idle();
    chk("R6", "ret0_valid still held", ret0_valid, 1);
    chk("R6", "ret0_tag held", ret0_tag, 3);
    ret_ready = 1;
    idle();
    chk("R6", "ret0_valid after handshake", ret0_valid, 0);

    // R7 store release only at head
    alloc(1); alloc(0);
    fin(5, 0);
    chk("R7", "no release below head", st_rel_valid, 0);
    fin(4, 0);
    chk("R7", "st_rel_valid", st_rel_valid, 1);
    chk("R7", "st_rel_tag", st_rel_tag, 4);
    chk("R5", "lane1 after store", ret1_valid, 1);
    idle();
    alloc(0); alloc(1); fin(7, 0); fin(6, 0);
    chk("R5", "store blocked on lane1", ret1_valid, 0);
    chk("R7", "no release for load", st_rel_valid, 0);
    idle();
    chk("R7", "store on lane0 tag", st_rel_tag, 7);
    chk("R7", "store on lane0 strobe", st_rel_valid, 1);
    idle();

    // R10 ignored finish reports
    ret_ready = 0;
    alloc(0); fin(0, 0); fin(0, 1); fin(3, 1);
    chk("R10", "exc_valid after late flag", exc_valid, 0);
    chk("R10", "ret0_valid", ret0_valid, 1);
    alloc(0); alloc(0); alloc(0); fin(3, 0);
    ret_ready = 1;
    fin(1, 0); fin(2, 0); idle(); idle();
    chk("R10", "drained ret0_valid", ret0_valid, 0);
    chk("R10", "drained exc_valid", exc_valid, 0);
    chk("R10", "alloc_tag", alloc_tag, 4);

    // R8 precise exception
    alloc(0); alloc(0); alloc(0);
    fin(6, 0); fin(5, 1); fin(4, 0);
    chk("R8", "ret0_tag before fault", ret0_tag, 4);
    chk("R5", "faulting entry not on lane1", ret1_valid, 0);
    idle();
    chk("R8", "exc_valid", exc_valid, 1);
    chk("R8", "exc_tag", exc_tag, 5);
    chk("R8", "no retire", ret0_valid, 0);
    chk("R8", "alloc_ready", alloc_ready, 0);
    idle();
    chk("R8", "exc cleared", exc_valid, 0);
    chk("R8", "tail rewound", alloc_tag, 5);
    chk("R8", "alloc_ready after", alloc_ready, 1);

    // R9 external flush
    alloc(0); alloc(0); fin(6, 0);
    drv(.fl(1));
    chk("R9", "alloc_tag", alloc_tag, 5);
    chk("R9", "ret0_valid", ret0_valid, 0);

    // R3 full
    for (int k = 0; k < DEPTH; k++) alloc(0);
    chk("R3", "alloc_ready full", alloc_ready, 0);
    drv(.av(1));
    chk("R3", "refused alloc keeps tag", alloc_tag, 5);
    fin(5, 0);
    chk("R3", "ready low while retiring", alloc_ready, 0);
    chk("R4", "ret0_valid full", ret0_valid, 1);
    idle();
    chk("R3", "ready after retire", alloc_ready, 1);
    drv(.fl(1));

    // random traffic checked by the scoreboard
    for (int n = 0; n < 4000; n++) begin
      ret_ready = ($urandom % 4) != 0;
      drv(.av($urandom % 2), .ast(($urandom % 3) == 0), .fv(($urandom % 3) != 0),
          .ft($urandom % 8), .fe(($urandom % 12) == 0), .sv($urandom % 2),
          .stg($urandom % 8), .fl(($urandom % 90) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule